// File: doc/BRIEF.md
# Triggered Capture/Playback Offload Buffer

This block holds a burst of stream words in local storage and hands them on later. One stream port fills the storage and the other drains it. Wired as a player, the host fills it and the converter side receives the replay. Wired as a capturer, the converter side fills it and the host drains it. A write sequencer decides when words are stored, and it can hold the start of storage until an external trigger arrives. A read sequencer then plays the stored burst either once or repeatedly.

A bypass setting skips the storage and both sequencers. Words then pass through a small first-in first-out queue. A level-sensitive software reset parks both sequencers. Each sequencer reports its state as a one-hot code so that software can read it without loss.

Top module: `cap_play_buffer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wr_state` reads 1, `rd_state` reads 1 and `out_valid` is low.
- R2: `wr_state` is one-hot over five bits: idle=1, arm=2, sync wait=4, store=8, wait-for-read=16. `rd_state` is one-hot over four bits: idle=1, pre-read=2, active=4, end=8.
- R3: With `cfg_hw_sync` low, a high `init_req` seen in idle moves the write side through arm into store. `cfg_hw_sync` is sampled only when idle is left.
- R4: With `cfg_hw_sync` high, the write side waits in sync wait (4). It enters store only on a cycle where `sync_ext` and `init_req` are both high. A `sync_ext` pulse while `init_req` is low is ignored.
- R5: Input beats offered before the store state are accepted (`in_ready` high) and discarded. They never appear at the output.
- R6: In store, each accepted beat is written in order. The beat carrying `in_last` (or the beat that fills DEPTH words) sets the stored length and moves the write side to wait-for-read (16). It stays there until the read side has finished.
- R7: After a fill, the read side enters pre-read (2). It leaves for active only on a cycle where `out_ready` is high.
- R8: With `cfg_oneshot` high, each stored word is output exactly once in order, with `out_last` high on the final word. `out_valid` then stays low and both sequencers return to idle.
- R9: With `cfg_oneshot` low, the stored words are replayed in order without end, `out_last` stays low, and the write side stays in wait-for-read.
- R10: While `soft_rst` is high, both sequencers read idle and `out_valid` is low. Once it is low again, a new transfer runs normally.
- R11: With `cfg_bypass` high, input words reach the output in order through a BYP_DEPTH-entry queue, `in_ready` drops when it is full, and `wr_state` stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Level software reset of both sequencers |
| cfg_hw_sync | input | 1 | Hold storage start for the external trigger |
| cfg_oneshot | input | 1 | 1: play once, 0: replay forever |
| cfg_bypass | input | 1 | Route through the small queue only |
| init_req | input | 1 | Request to begin a transfer |
| sync_ext | input | 1 | External start trigger |
| in_valid | input | 1 | Input word valid |
| in_data | input | DW | Input word |
| in_last | input | 1 | Final input word of a burst |
| in_ready | output | 1 | Input word accepted |
| out_valid | output | 1 | Output word valid |
| out_data | output | DW | Output word |
| out_last | output | 1 | Final word of a once-only playback |
| out_ready | input | 1 | Output consumer ready |
| wr_state | output | 5 | One-hot write sequencer state |
| rd_state | output | 4 | One-hot read sequencer state |

## Verification
The main function is driven with four input patterns:
- A free-start once-only burst preceded by junk beats shows whether early data is really dropped and whether `out_last` lands on the right word.
- A triggered burst with a trigger pulse outside the request window tells a gated start from a start on any trigger edge. Holding `out_ready` low in the same run shows whether the read side waits in pre-read.
- A cyclic burst tells endless replay from a single pass. It is then cut short by the software reset, and a further burst shows that the block runs again afterwards.
- A bypass burst that fills the queue checks ordering, back-pressure and that the sequencers stay untouched.

// File: rtl/cpb_pkg.sv
// Shared state codes for the capture/playback buffer.
// States are one-hot so that a status readback never truncates them.
package cpb_pkg;
    typedef enum logic [4:0] {
        WR_IDLE  = 5'b00001,
        WR_ARM   = 5'b00010,
        WR_SYNC  = 5'b00100,
        WR_STORE = 5'b01000,
        WR_WAIT  = 5'b10000
    } wr_state_t;

    typedef enum logic [3:0] {
        RD_IDLE   = 4'b0001,
        RD_PRE    = 4'b0010,
        RD_ACTIVE = 4'b0100,
        RD_END    = 4'b1000
    } rd_state_t;
endpackage

// File: rtl/cpb_store.sv
// Word storage: one write port, one asynchronous read port.
// Assumes the write and read sequencers never touch the same burst at once.
module cpb_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/cpb_byp_fifo.sv
// Small pass-through queue used when the block is bypassed.
// Assumes DEPTH is a power of two.
module cpb_byp_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    output logic          not_full,
    input  logic          pop,
    output logic          not_empty,
    output logic [DW-1:0] head
);
    logic [DW-1:0] q [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign not_full  = (cnt < (AW+1)'(DEPTH));
    assign not_empty = (cnt != '0);
    assign head      = q[rp];

    // Write entries into the queue.
    always_ff @(posedge clk) begin
        if (push && not_full) q[wp] <= push_data;
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push && not_full) wp <= wp + 1'b1;
            if (pop && not_empty) rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(push && not_full) - (AW+1)'(pop && not_empty);
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/cpb_wr_fsm.sv
// Write sequencer: waits for a request (and optionally a trigger),
// stores one burst, then waits until the read side reports it has finished.
// Assumes in_valid beats outside the store state are to be dropped.
module cpb_wr_fsm
    import cpb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cfg_hw_sync,
    input  logic          cfg_bypass,
    input  logic          init_req,
    input  logic          sync_ext,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          rd_done,
    output wr_state_t     state,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   len,
    output logic          fill_done
);
    wr_state_t nxt;
    logic      hw_mode;
    logic      end_beat;

    assign we       = (state == WR_STORE) && in_valid;
    assign waddr    = waddr_q;
    assign end_beat = in_last || (waddr_q == AW'(DEPTH - 1));
    assign fill_done = we && end_beat;

    logic [AW-1:0] waddr_q;

    // Next-state choice for the write sequencer.
    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:  if (init_req && !cfg_bypass) nxt = WR_ARM;
            WR_ARM:   nxt = hw_mode ? WR_SYNC : WR_STORE;
            WR_SYNC:  if (sync_ext && init_req) nxt = WR_STORE;
            WR_STORE: if (fill_done) nxt = WR_WAIT;
            WR_WAIT:  if (rd_done) nxt = WR_IDLE;
            default:  nxt = WR_IDLE;
        endcase
    end

    // State register, sync-mode latch, address counter and length capture.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state   <= WR_IDLE;
            hw_mode <= 1'b0;
            waddr_q <= '0;
            len     <= '0;
        end else begin
            state <= nxt;
            if (state == WR_IDLE) begin
                hw_mode <= cfg_hw_sync;
                waddr_q <= '0;
            end
            if (we) begin
                waddr_q <= waddr_q + 1'b1;
                if (end_beat) len <= {1'b0, waddr_q} + 1'b1;
            end
        end
    end

    a_r2_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
    a_r4_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_STORE && $past(state) == WR_SYNC) |-> $past(sync_ext && init_req));
    a_r10_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> state == WR_IDLE);
    a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_WAIT && !rd_done && !soft_rst) |=> state == WR_WAIT);
endmodule

// File: rtl/cpb_rd_fsm.sv
// Read sequencer: after a fill, waits for the consumer to be ready, then
// plays the stored words once (with a final marker) or replays them forever.
// Assumes len is between 1 and DEPTH while a burst is held.
module cpb_rd_fsm
    import cpb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cfg_oneshot,
    input  logic          fill_done,
    input  logic [AW:0]   len,
    input  logic          ready,
    output rd_state_t     state,
    output logic [AW-1:0] raddr,
    output logic          valid,
    output logic          last,
    output logic          rd_done
);
    rd_state_t nxt;
    logic      once;
    logic      at_end;
    logic      beat;

    assign valid   = (state == RD_ACTIVE);
    assign beat    = valid && ready;
    assign at_end  = ({1'b0, raddr} + 1'b1) == len;
    assign last    = valid && once && at_end;
    assign rd_done = (state == RD_END);

    // Next-state choice for the read sequencer.
    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:   if (fill_done) nxt = RD_PRE;
            RD_PRE:    if (ready) nxt = RD_ACTIVE;
            RD_ACTIVE: if (beat && at_end && once) nxt = RD_END;
            RD_END:    nxt = RD_IDLE;
            default:   nxt = RD_IDLE;
        endcase
    end

    // State register, mode latch and read address with wrap-around.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state <= RD_IDLE;
            once  <= 1'b1;
            raddr <= '0;
        end else begin
            state <= nxt;
            if (state == RD_IDLE) begin
                once  <= cfg_oneshot;
                raddr <= '0;
            end
            if (beat) raddr <= at_end ? '0 : raddr + 1'b1;
        end
    end

    a_r2_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1);
    a_r7_pre_leave: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_PRE && ready && !soft_rst) |=> state == RD_ACTIVE);
    a_r8_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_END) |-> $past(last && ready));
    a_r10_soft_idle: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> state == RD_IDLE);
endmodule

// File: rtl/cap_play_buffer.sv
// Capture/playback offload buffer top: storage plus write and read
// sequencers, with a bypass queue selected by cfg_bypass.
// Assumes cfg_bypass changes only while both sequencers are idle.
module cap_play_buffer
    import cpb_pkg::*;
#(
    parameter int DW        = 16,
    parameter int DEPTH     = 16,
    parameter int BYP_DEPTH = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cfg_hw_sync,
    input  logic          cfg_oneshot,
    input  logic          cfg_bypass,
    input  logic          init_req,
    input  logic          sync_ext,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    input  logic          out_ready,
    output logic [4:0]    wr_state,
    output logic [3:0]    rd_state
);
    wr_state_t     ws;
    rd_state_t     rs;
    logic          we, fill_done, rd_done;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   len;
    logic [DW-1:0] rdata, f_head;
    logic          r_valid, r_last;
    logic          f_not_full, f_not_empty;

    cpb_wr_fsm #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_hw_sync(cfg_hw_sync), .cfg_bypass(cfg_bypass),
        .init_req(init_req), .sync_ext(sync_ext),
        .in_valid(in_valid && !cfg_bypass), .in_last(in_last),
        .rd_done(rd_done), .state(ws), .we(we), .waddr(waddr),
        .len(len), .fill_done(fill_done)
    );

    cpb_rd_fsm #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_oneshot(cfg_oneshot), .fill_done(fill_done), .len(len),
        .ready(out_ready && !cfg_bypass), .state(rs), .raddr(raddr),
        .valid(r_valid), .last(r_last), .rd_done(rd_done)
    );

    cpb_store #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
        .raddr(raddr), .rdata(rdata)
    );

    cpb_byp_fifo #(.DW(DW), .DEPTH(BYP_DEPTH)) u_byp (
        .clk(clk), .rst_n(rst_n),
        .push(cfg_bypass && in_valid), .push_data(in_data), .not_full(f_not_full),
        .pop(cfg_bypass && out_ready), .not_empty(f_not_empty), .head(f_head)
    );

    // Select between the bypass queue and the stored-burst path.
    always_comb begin
        if (cfg_bypass) begin
            in_ready  = f_not_full;
            out_valid = f_not_empty;
            out_data  = f_head;
            out_last  = 1'b0;
        end else begin
            in_ready  = 1'b1;
            out_valid = r_valid && !soft_rst;
            out_data  = rdata;
            out_last  = r_last && !soft_rst;
        end
    end

    assign wr_state = ws;
    assign rd_state = rs;

    a_r11_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bypass && ws == WR_IDLE) |=> ws == WR_IDLE);
    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && cfg_oneshot));
endmodule

// File: tb/test_cap_play_buffer.sv
module test_cap_play_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
    logic cfg_hw_sync = 1'b0, cfg_oneshot = 1'b1, cfg_bypass = 1'b0;
    logic init_req = 1'b0, sync_ext = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid, out_last;
    logic [DW-1:0] out_data;
    logic [4:0] wr_state;
    logic [3:0] rd_state;

    int checks = 0, fails = 0;
    bit strict = 1'b1;
    bit done = 1'b0;
    logic [DW:0] expq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_play_buffer i_cap_play_buffer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_hw_sync(cfg_hw_sync), .cfg_oneshot(cfg_oneshot), .cfg_bypass(cfg_bypass),
        .init_req(init_req), .sync_ext(sync_ext),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .wr_state(wr_state), .rd_state(rd_state)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on each output handshake.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (expq.size() > 0) begin
                logic [DW:0] e;
                e = expq.pop_front();
                check("R8/R9/R11 out word", {out_last, out_data}, e);
            end else if (strict) begin
                check("R8 extra beat", 32'd1, 32'd0);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_wr(input logic [4:0] s);
        for (int i = 0; i < 200 && wr_state !== s; i++) tick(1);
    endtask

    // Driver: send a burst, pushing expected words when asked.
    task automatic send(input int n, input logic [DW-1:0] base, input bit expect_it, input bit lst);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = base + DW'(i);
            in_last  = (i == n - 1);
            if (expect_it) expq.push_back({lst && (i == n - 1), base + DW'(i)});
            tick(1);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 500 && expq.size() > 0; i++) tick(1);
        check("R8 scoreboard empty", expq.size(), 0);
    endtask

    initial begin
        tick(3);
        check("R1 wr_state reset", wr_state, 5'd1);
        check("R1 rd_state reset", rd_state, 4'd1);
        check("R1 out_valid reset", out_valid, 1'b0);
        rst_n = 1'b1;
        tick(1);

        // Free start, once-only, junk beats first (R3, R5, R6, R8).
        out_ready = 1'b1;
        in_valid = 1'b1; in_data = 16'hBAD0;
        tick(2);
        check("R5 in_ready while idle", in_ready, 1'b1);
        in_valid = 1'b0;
        init_req = 1'b1;
        tick(1);
        check("R3 arm state", wr_state, 5'd2);
        init_req = 1'b0;
        tick(1);
        check("R3 store state", wr_state, 5'd8);
        send(4, 16'h1000, 1'b1, 1'b1);
        drain();
        tick(3);
        check("R8 wr back to idle", wr_state, 5'd1);
        check("R8 rd back to idle", rd_state, 4'd1);
        check("R8 out_valid low after", out_valid, 1'b0);

        // Triggered start with out-of-window trigger (R4, R6, R7).
        cfg_hw_sync = 1'b1;
        out_ready = 1'b0;
        init_req = 1'b1;
        tick(3);
        check("R4 sync wait", wr_state, 5'd4);
        in_valid = 1'b1; in_data = 16'hBAD1;
        init_req = 1'b0;
        sync_ext = 1'b1;
        tick(1);
        sync_ext = 1'b0;
        in_valid = 1'b0;
        tick(1);
        check("R4 trigger without request ignored", wr_state, 5'd4);
        init_req = 1'b1; sync_ext = 1'b1;
        tick(1);
        init_req = 1'b0; sync_ext = 1'b0;
        check("R4 store after trigger", wr_state, 5'd8);
        send(3, 16'h2000, 1'b1, 1'b1);
        check("R6 wait-for-read", wr_state, 5'd16);
        tick(3);
        check("R7 held in pre-read", rd_state, 4'd2);
        check("R6 still waiting", wr_state, 5'd16);
        out_ready = 1'b1;
        tick(1);
        check("R7 active after ready", rd_state, 4'd4);
        drain();
        tick(3);
        check("R8 idle after triggered burst", wr_state, 5'd1);
        cfg_hw_sync = 1'b0;

        // Cyclic replay, then software reset (R9, R10).
        cfg_oneshot = 1'b0;
        strict = 1'b0;
        init_req = 1'b1;
        tick(1);
        init_req = 1'b0;
        wait_wr(5'd8);
        send(3, 16'h3000, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) expq.push_back({1'b0, 16'h3000 + DW'(k % 3)});
        drain();
        check("R9 wr stays waiting", wr_state, 5'd16);
        check("R9 still playing", out_valid, 1'b1);
        soft_rst = 1'b1;
        tick(2);
        check("R10 wr idle in soft reset", wr_state, 5'd1);
        check("R10 rd idle in soft reset", rd_state, 4'd1);
        check("R10 out_valid low", out_valid, 1'b0);
        soft_rst = 1'b0;
        strict = 1'b1;
        cfg_oneshot = 1'b1;
        tick(1);
        init_req = 1'b1;
        tick(1);
        init_req = 1'b0;
        wait_wr(5'd8);
        check("R10 resumes to store", wr_state, 5'd8);
        send(2, 16'h4000, 1'b1, 1'b1);
        drain();
        tick(3);

        // Bypass path (R11).
        cfg_bypass = 1'b1;
        out_ready = 1'b0;
        init_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_data = 16'h5000 + DW'(i);
            expq.push_back({1'b0, 16'h5000 + DW'(i)});
            tick(1);
        end
        in_valid = 1'b0;
        init_req = 1'b0;
        check("R11 full drops in_ready", in_ready, 1'b0);
        check("R11 wr stays idle", wr_state, 5'd1);
        out_ready = 1'b1;
        drain();
        check("R11 in_ready after drain", in_ready, 1'b1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule